// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

This block counts prescaler ticks and raises a one-cycle reset request when software fails to service it in time. Servicing is a two-step handshake: software writes the byte 0x55 to the service register and then the byte 0xAA. Only that ordered pair clears the count. A single write, a stray pulse or a lone 0xAA does not.

The timeout comes from a two-bit rate code that picks one of four powers of two. A single enable input switches the whole timer on or off. The reset request only asks for a reset. The reset sequencer downstream turns it into the actual system reset. The register write port is a plain address/data/strobe bus, and the service register sits at one parameterised address.

Top module: `wdog_keyed`

## Requirements
- R1: While `rst` is high the count is zero and `wdog_rst` is low, and after reset the timer begins counting from zero.
- R2: With `enable` high and a tick in every counted cycle, `wdog_rst` pulses after exactly 2^(BASE_LOG2 + STEP_LOG2*code) ticks, where code is the value of `rate_sel` (0..3). With the defaults this gives 2^15, 2^17, 2^19 and 2^21 ticks.
- R3: `wdog_rst` is high for a single clock cycle. In that cycle the count is back at zero, so the next pulse follows a further full timeout.
- R4: A write of 0x55 to address SVC_ADDR, followed by a write of 0xAA to that address with no other write to that address in between, clears the count. The clear takes effect on the second clock edge after the 0xAA write.
- R5: A 0xAA write to SVC_ADDR does not clear the count unless the previous write to SVC_ADDR was 0x55. This covers a lone 0xAA and 0x55 followed by some other value and then 0xAA.
- R6: Repeated 0x55 writes to SVC_ADDR never clear the count by themselves. An 0xAA after the last of them does clear it.
- R7: Writes to any address other than SVC_ADDR have no effect. They neither arm nor complete nor break the key sequence.
- R8: While `enable` is low the count is held at zero and `wdog_rst` stays low. After `enable` returns high, a full timeout is needed before a pulse.
- R9: In a cycle with `tick` low the count holds and no pulse is issued.
- R10: If `rate_sel` is changed to a timeout the count has already reached, the next tick expires the timer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Watchdog on (1) or off (0) |
| rate_sel | input | 2 | Timeout rate code 0..3 |
| tick | input | 1 | Prescaler tick, one-cycle strobe |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | 8 | Register write data |
| wdog_rst | output | 1 | One-cycle timeout reset request |

## Verification
The properties rely on two assumptions:
- `rst` is driven to a known value from the first clock edge.
- `tick`, `enable` and the write strobe are ordinary synchronous levels that change only between edges.

The stimulus changes every input on the falling edge, holds `tick` low during register writes so that clear timing can be counted exactly, and starts each scenario from a fresh reset. Expected pulse positions are computed as 2^(3 + 2*code) ticks for the reduced bench configuration.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int          KEY_W    = 8;
    localparam int          RATE_W   = 2;
    localparam int          N_RATES  = 1 << RATE_W;
    localparam logic [KEY_W-1:0] KEY_ARM  = 8'h55;
    localparam logic [KEY_W-1:0] KEY_FIRE = 8'hAA;

    typedef logic [RATE_W-1:0] rate_t;

    typedef enum logic [0:0] {
        SEQ_IDLE  = 1'b0,
        SEQ_ARMED = 1'b1
    } seq_state_e;

    typedef struct packed {
        seq_state_e nxt;
        logic       fire;
    } seq_step_t;

    // Next key-sequence state for one write to the service register.
    function automatic seq_step_t seq_step(seq_state_e cur, logic [KEY_W-1:0] d);
        seq_step_t s;
        s.fire = 1'b0;
        s.nxt  = SEQ_IDLE;
        if (d == KEY_ARM) begin
            s.nxt = SEQ_ARMED;
        end else if (d == KEY_FIRE && cur == SEQ_ARMED) begin
            s.fire = 1'b1;
        end
        return s;
    endfunction

endpackage

// File: rtl/wdog_key_seq.sv
module wdog_key_seq
    import wdog_pkg::*;
#(
    parameter int              ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] SVC_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [KEY_W-1:0]  wr_data,
    output logic              svc_clr
);

    seq_state_e st_q;
    seq_step_t  step;
    logic       hit;

    assign hit = wr_en && (wr_addr == SVC_ADDR);

    always_comb step = seq_step(st_q, wr_data);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= SEQ_IDLE;
            svc_clr <= 1'b0;
        end else begin
            svc_clr <= hit && step.fire;
            if (hit) begin
                st_q <= step.nxt;
            end
        end
    end

endmodule

// File: rtl/wdog_rate_lut.sv
module wdog_rate_lut
    import wdog_pkg::*;
#(
    parameter int BASE_LOG2 = 15,
    parameter int STEP_LOG2 = 2,
    parameter int CNT_W     = BASE_LOG2 + (N_RATES - 1) * STEP_LOG2
) (
    input  rate_t             rate_sel,
    output logic [CNT_W-1:0]  term
);

    logic [CNT_W-1:0] terms [N_RATES];

    for (genvar g = 0; g < N_RATES; g++) begin : g_rate
        localparam int LOG2 = BASE_LOG2 + g * STEP_LOG2;
        assign terms[g] = CNT_W'((64'd1 << LOG2) - 64'd1);
    end

    assign term = terms[rate_sel];

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
    parameter int CNT_W = 21
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             tick,
    input  logic             svc_clr,
    input  logic [CNT_W-1:0] term,
    output logic [CNT_W-1:0] cnt,
    output logic             expire
);

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            cnt    <= '0;
            expire <= 1'b0;
        end else if (svc_clr) begin
            cnt    <= '0;
            expire <= 1'b0;
        end else if (tick) begin
            if (cnt >= term) begin
                cnt    <= '0;
                expire <= 1'b1;
            end else begin
                cnt    <= cnt + 1'b1;
                expire <= 1'b0;
            end
        end else begin
            expire <= 1'b0;
        end
    end

endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed
    import wdog_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] SVC_ADDR  = 8'h0C,
    parameter int                BASE_LOG2 = 15,
    parameter int                STEP_LOG2 = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic [1:0]        rate_sel,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output logic              wdog_rst
);

    localparam int CNT_W = BASE_LOG2 + (N_RATES - 1) * STEP_LOG2;

    logic             svc_clr;
    logic [CNT_W-1:0] term;
    logic [CNT_W-1:0] cnt_q;

    wdog_key_seq #(
        .ADDR_W   (ADDR_W),
        .SVC_ADDR (SVC_ADDR)
    ) key_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .svc_clr (svc_clr)
    );

    wdog_rate_lut #(
        .BASE_LOG2 (BASE_LOG2),
        .STEP_LOG2 (STEP_LOG2),
        .CNT_W     (CNT_W)
    ) lut_i (
        .rate_sel (rate_sel),
        .term     (term)
    );

    wdog_counter #(
        .CNT_W (CNT_W)
    ) cnt_i (
        .clk     (clk),
        .rst     (rst),
        .enable  (enable),
        .tick    (tick),
        .svc_clr (svc_clr),
        .term    (term),
        .cnt     (cnt_q),
        .expire  (wdog_rst)
    );

endmodule

// File: rtl/wdog_keyed_chk.sv
module wdog_keyed_chk #(
    parameter int CNT_W = 21
) (
    input logic             clk,
    input logic             rst,
    input logic             enable,
    input logic             tick,
    input logic             svc_clr,
    input logic [CNT_W-1:0] cnt,
    input logic             wdog_rst
);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (cnt == '0 && !wdog_rst));

    // R3
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        wdog_rst |=> !wdog_rst);

    // R3
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        wdog_rst |-> cnt == '0);

    // R4
    key_clear_chk: assert property (@(posedge clk) disable iff (rst)
        svc_clr |=> cnt == '0);

    // R8
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (cnt == '0 && !wdog_rst));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (enable && !tick && !svc_clr) |=> ($stable(cnt) && !wdog_rst));

endmodule

bind wdog_keyed wdog_keyed_chk #(.CNT_W(CNT_W)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .enable   (enable),
    .tick     (tick),
    .svc_clr  (svc_clr),
    .cnt      (cnt_q),
    .wdog_rst (wdog_rst)
);

// File: tb/wdog_keyed_tb_top.sv
module wdog_keyed_tb_top;

    localparam int          ADDR_W = 8;
    localparam logic [7:0]  SVC    = 8'h0C;
    localparam logic [7:0]  OTHER  = 8'h0D;
    localparam int          BASE   = 3;
    localparam int          STEP   = 2;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             enable = 1'b0;
    logic [1:0]       rate_sel = 2'd0;
    logic             tick = 1'b0;
    logic             wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [7:0]       wr_data = '0;
    logic             wdog_rst;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    wdog_keyed #(
        .ADDR_W    (ADDR_W),
        .SVC_ADDR  (SVC),
        .BASE_LOG2 (BASE),
        .STEP_LOG2 (STEP)
    ) dut_i (
        .clk      (clk),
        .rst      (rst),
        .enable   (enable),
        .rate_sel (rate_sel),
        .tick     (tick),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .wdog_rst (wdog_rst)
    );

    always #4 clk = ~clk;

    function automatic int limit_of(input int code);
        return 1 << (BASE + STEP * code);
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: wdog_rst=%b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        enable = 1'b1;
        tick = 1'b0;
        wr_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R1", wdog_rst, 1'b0);
        rst = 1'b0;
    endtask

    // Tick every cycle for n cycles; pulse expected on multiples of 'at'.
    task automatic run(input string req, input int n, input int at);
        tick = 1'b1;
        for (int i = 1; i <= n; i++) begin
            @(negedge clk);
            check(req, wdog_rst, (at != 0) && (i % at == 0));
        end
        tick = 1'b0;
    endtask

    task automatic idle(input string req, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check(req, wdog_rst, 1'b0);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        wr_en = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        @(negedge clk);
        do_reset();

        // R2 R3: every rate code, two consecutive timeouts
        for (int r = 0; r < 4; r++) begin
            rate_sel = 2'(r);
            do_reset();
            run("R2_R3", 2 * limit_of(r) + 2, limit_of(r));
        end

        rate_sel = 2'd0;

        // R4: ordered key pair clears
        do_reset();
        run("R4", 5, 0);
        wr(SVC, 8'h55); wr(SVC, 8'hAA);
        idle("R4", 1);
        run("R4", 9, 8);

        // R5: interrupted sequence does not clear
        do_reset();
        run("R5", 5, 0);
        wr(SVC, 8'h55); wr(SVC, 8'h12); wr(SVC, 8'hAA);
        idle("R5", 1);
        run("R5", 3, 3);
        // R5: lone 0xAA does not clear
        do_reset();
        run("R5", 5, 0);
        wr(SVC, 8'hAA);
        idle("R5", 1);
        run("R5", 3, 3);

        // R6: repeated 0x55 does not clear, then 0xAA does
        do_reset();
        run("R6", 5, 0);
        wr(SVC, 8'h55); wr(SVC, 8'h55);
        idle("R6", 1);
        run("R6", 3, 3);
        run("R6", 5, 0);
        wr(SVC, 8'h55); wr(SVC, 8'h55); wr(SVC, 8'hAA);
        idle("R6", 1);
        run("R6", 8, 8);

        // R7: other address neither breaks nor arms
        do_reset();
        run("R7", 5, 0);
        wr(SVC, 8'h55); wr(OTHER, 8'h00); wr(SVC, 8'hAA);
        idle("R7", 1);
        run("R7", 8, 8);
        do_reset();
        run("R7", 5, 0);
        wr(OTHER, 8'h55); wr(SVC, 8'hAA);
        idle("R7", 1);
        run("R7", 3, 3);

        // R8: disabled never fires, restarts from zero
        do_reset();
        enable = 1'b0;
        run("R8", 600, 0);
        enable = 1'b1;
        run("R8", 8, 8);
        run("R8", 5, 0);
        enable = 1'b0;
        idle("R8", 1);
        enable = 1'b1;
        run("R8", 8, 8);

        // R9: no tick holds the count
        do_reset();
        run("R9", 5, 0);
        idle("R9", 50);
        run("R9", 3, 3);

        // R10: lowering the rate below the count expires at next tick
        rate_sel = 2'd3;
        do_reset();
        run("R10", 100, 0);
        rate_sel = 2'd0;
        run("R10", 1, 1);
        run("R10", 8, 8);

        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: run did not end, got hang expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule